// File: doc/BRIEF.md
# Vendor Control Request Dispatcher

This block sits behind a USB device controller that has already split each control setup packet into its fields. It takes the request code, the low byte of the value field and the transfer direction, and for a small set of vendor commands either changes a few output registers (a voltage-boost flag that picks an 8-bit regulator control byte, a general-purpose output byte and its output-enable mask) or builds a short response of up to six bytes with a byte count. The firmware or endpoint-zero logic around it forwards the response to the host, or returns a protocol stall when the block flags the request as rejected.

Request codes are range checked against a table whose size is a parameter: 30 entries for the full command set, 27 for the reduced one. Codes outside the table, codes inside it that this block does not serve (including the commands that would need an EEPROM read), and requests whose direction does not match the command are all rejected without touching any state. Each request strobe gives exactly one completion pulse on the next clock.

Top module: `vreq_dispatch`

## Requirements
- R1: Every cycle with `req_valid` high is followed on the next cycle by exactly one cycle of `rsp_done` high; `rsp_done` is low after any cycle without `req_valid`, and `req_code` and `req_value` have no effect while `req_valid` is low.
- R2: A code is in range only if it is at least 0x80 and (code − 0x80) is below `TABLE_SIZE` (30 by default, 27 for the reduced set); an out-of-range request gives `rsp_done` and `rsp_stall` together, `rsp_len` 0, `rsp_data` 0, and no change to `lnb_ctrl`, `gpio_out`, `gpio_oe` or the counter.
- R3: An in-range request is also rejected in the same way when its code is not one of 0x91, 0x92, 0x94, 0x96, 0x97, 0x98, or when `req_dir_in` (1 = device-to-host) does not match the command: 0x91, 0x92, 0x98 need 1; 0x94, 0x96, 0x97 need 0.
- R4: Code 0x91 adds one to an 8-bit counter when `req_value` is non-zero and subtracts one when it is zero, wrapping modulo 256 both ways, and responds with `rsp_len` 1 and the updated count in `rsp_data[7:0]`; the counter resets to 0.
- R5: Code 0x92 responds with `rsp_len` 6 and the six version constants, byte k in `rsp_data[8k+7:8k]`: k=0 version minor-minor, 1 version minor, 2 version major, 3 build day, 4 build month, 5 build year counted from 2000.
- R6: Code 0x94 sets the boost flag to (`req_value` != 0); `lnb_ctrl` reads 0x6A while the flag is set and 0x62 while it is clear, and resets to 0x62.
- R7: Code 0x96 with a non-zero value clears `gpio_out` bit 3, sets bits 2 and 1, keeps the other bits and loads `gpio_oe` with 0xFE; with a zero value it loads `gpio_oe` with 0xF0 and leaves `gpio_out` alone. Reset values are `gpio_out` 0x00 and `gpio_oe` 0xF0.
- R8: Code 0x97 copies `req_value` bits [3:1] into `gpio_out` bits [3:1] and keeps `gpio_out` bits 7:4 and 0.
- R9: Code 0x98 responds with `rsp_len` 1 and `rsp_data[7:0]` equal to `status_in` bit 0 (so 0 or 1) as sampled in the request cycle.
- R10: Accepted host-to-device commands complete with `rsp_len` 0; in every response the bytes at and above `rsp_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe marking a parsed setup request |
| req_code | input | 8 | Vendor request code |
| req_value | input | 8 | Low byte of the setup value field |
| req_dir_in | input | 1 | 1 = device-to-host, 0 = host-to-device |
| status_in | input | 8 | Input port; bit 0 is the status line read by 0x98 |
| rsp_done | output | 1 | Completion pulse, one cycle after each request |
| rsp_stall | output | 1 | High with `rsp_done` when the request was rejected |
| rsp_len | output | 3 | Response byte count |
| rsp_data | output | 48 | Response bytes, byte 0 in bits 7:0 |
| lnb_ctrl | output | 8 | Regulator control byte selected by the boost flag |
| gpio_out | output | 8 | General-purpose output byte |
| gpio_oe | output | 8 | Output-enable mask for `gpio_out` |

## Verification
The assertions check on every cycle that completion follows each strobe by exactly one cycle, that a stalled or host-to-device completion carries a zero count, that nothing outside a matching accepted request moves the output registers, that a pin write keeps the untouched bits, and that the regulator byte and the counter step follow the value of the request that changed them. The exact version byte order, counter wrap in both directions, the rejection of EEPROM-backed and direction-mismatched codes, and the interplay of the enable-mode and pin-write commands on the same output byte are only shown by the bench scenarios against its reference model.

// File: rtl/vreq_pkg.sv
package vreq_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_COUNT,
        K_VERSION,
        K_BOOST,
        K_OEMODE,
        K_PINS,
        K_STATUS
    } kind_e;

    localparam logic [7:0] OPC_BASE    = 8'h80;
    localparam logic [7:0] OPC_COUNT   = 8'h91;
    localparam logic [7:0] OPC_VERSION = 8'h92;
    localparam logic [7:0] OPC_BOOST   = 8'h94;
    localparam logic [7:0] OPC_OEMODE  = 8'h96;
    localparam logic [7:0] OPC_PINS    = 8'h97;
    localparam logic [7:0] OPC_STATUS  = 8'h98;

    localparam logic [7:0] LNB_NORMAL  = 8'h62;
    localparam logic [7:0] LNB_BOOST   = 8'h6A;
    localparam logic [7:0] OE_DEFAULT  = 8'hF0;
    localparam logic [7:0] OE_ACTIVE   = 8'hFE;

    localparam int RESP_BYTES = 6;
    localparam int LEN_W      = $clog2(RESP_BYTES + 1);

    // Commands that send data to the host
    function automatic logic kind_is_in(kind_e k);
        return (k == K_COUNT) || (k == K_VERSION) || (k == K_STATUS);
    endfunction

endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
    import vreq_pkg::*;
#(
    parameter int TABLE_SIZE = 30
) (
    input  logic [7:0] code,
    input  logic       dir_in,
    output kind_e      kind,
    output logic       accept
);

    logic [7:0] idx;
    logic       in_range;
    kind_e      raw;

    always_comb begin
        idx      = code - OPC_BASE;
        in_range = code[7] && ({24'd0, idx} < TABLE_SIZE);
        case (code)
            OPC_COUNT:   raw = K_COUNT;
            OPC_VERSION: raw = K_VERSION;
            OPC_BOOST:   raw = K_BOOST;
            OPC_OEMODE:  raw = K_OEMODE;
            OPC_PINS:    raw = K_PINS;
            OPC_STATUS:  raw = K_STATUS;
            default:     raw = K_NONE;
        endcase
        // R2 range, R3 implemented set and direction match
        accept = in_range && (raw != K_NONE) && (kind_is_in(raw) == dir_in);
        kind   = accept ? raw : K_NONE;
    end

endmodule

// File: rtl/vreq_portctl.sv
module vreq_portctl
    import vreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  kind_e      kind,
    input  logic [7:0] val,
    output logic [7:0] lnb_ctrl,
    output logic [7:0] gpio_out,
    output logic [7:0] gpio_oe
);

    typedef struct packed {
        logic       boost;
        logic [7:0] pins;
        logic [7:0] oe;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            case (kind)
                K_BOOST: st_d.boost = |val;
                K_OEMODE: begin
                    if (|val) begin
                        st_d.pins = (st_q.pins & 8'hF7) | 8'h06;
                        st_d.oe   = OE_ACTIVE;
                    end else begin
                        st_d.oe   = OE_DEFAULT;
                    end
                end
                K_PINS: st_d.pins = (st_q.pins & 8'hF1) | (val & 8'h0E);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.boost <= 1'b0;
            st_q.pins  <= 8'h00;
            st_q.oe    <= OE_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign lnb_ctrl = st_q.boost ? LNB_BOOST : LNB_NORMAL;
    assign gpio_out = st_q.pins;
    assign gpio_oe  = st_q.oe;

    // R6: regulator byte follows the value of the boost request
    p_boost_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == K_BOOST) |=>
            (lnb_ctrl == ($past(|val) ? LNB_BOOST : LNB_NORMAL)));

    // R8: pin write keeps bits 7:4 and 0
    p_pins_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == K_PINS) |=>
            (gpio_out[0] == $past(gpio_out[0]) && gpio_out[7:4] == $past(gpio_out[7:4])));

    // R2: without an accepted request the port state holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(lnb_ctrl) && $stable(gpio_out) && $stable(gpio_oe)));

endmodule

// File: rtl/vreq_resp.sv
module vreq_resp
    import vreq_pkg::*;
#(
    parameter logic [7:0] VER_PATCH = 8'h03,
    parameter logic [7:0] VER_MINOR = 8'h07,
    parameter logic [7:0] VER_MAJOR = 8'h02,
    parameter logic [7:0] BUILD_DAY = 8'h15,
    parameter logic [7:0] BUILD_MON = 8'h06,
    parameter logic [7:0] BUILD_YR  = 8'h0B
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      accept,
    input  kind_e                     kind,
    input  logic [7:0]                val,
    input  logic                      status_bit,
    output logic                      done,
    output logic                      stall,
    output logic [LEN_W-1:0]          len,
    output logic [8*RESP_BYTES-1:0]   data
);

    typedef struct packed {
        logic [7:0]              cnt;
        logic                    done;
        logic                    stall;
        logic [LEN_W-1:0]        len;
        logic [8*RESP_BYTES-1:0] data;
    } rsp_st_t;

    rsp_st_t r_d, r_q;
    logic [7:0] cnt_next;

    always_comb begin
        cnt_next  = (|val) ? r_q.cnt + 8'd1 : r_q.cnt - 8'd1;
        r_d       = r_q;
        r_d.done  = req_valid;
        r_d.stall = req_valid && !accept;
        r_d.len   = '0;
        r_d.data  = '0;
        if (req_valid && accept) begin
            case (kind)
                K_COUNT: begin
                    r_d.cnt       = cnt_next;
                    r_d.len       = LEN_W'(1);
                    r_d.data[7:0] = cnt_next;
                end
                K_VERSION: begin
                    r_d.len  = LEN_W'(RESP_BYTES);
                    r_d.data = {BUILD_YR, BUILD_MON, BUILD_DAY,
                                VER_MAJOR, VER_MINOR, VER_PATCH};
                end
                K_STATUS: begin
                    r_d.len     = LEN_W'(1);
                    r_d.data[0] = status_bit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done  = r_q.done;
    assign stall = r_q.stall;
    assign len   = r_q.len;
    assign data  = r_q.data;

    // R1: completion exactly one cycle after each strobe
    p_done_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);

    // R2: a rejected request carries no data
    p_stall_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (done && len == '0 && data == '0));

    // R4: one step per counter request, returned value is the new count
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && accept && kind == K_COUNT) |=>
            (data[7:0] == ($past(|val) ? $past(r_q.cnt) + 8'd1 : $past(r_q.cnt) - 8'd1)));

endmodule

// File: rtl/vreq_dispatch.sv
module vreq_dispatch
    import vreq_pkg::*;
#(
    parameter int         TABLE_SIZE = 30,
    parameter logic [7:0] VER_PATCH  = 8'h03,
    parameter logic [7:0] VER_MINOR  = 8'h07,
    parameter logic [7:0] VER_MAJOR  = 8'h02,
    parameter logic [7:0] BUILD_DAY  = 8'h15,
    parameter logic [7:0] BUILD_MON  = 8'h06,
    parameter logic [7:0] BUILD_YR   = 8'h0B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [7:0]  req_code,
    input  logic [7:0]  req_value,
    input  logic        req_dir_in,
    input  logic [7:0]  status_in,
    output logic        rsp_done,
    output logic        rsp_stall,
    output logic [2:0]  rsp_len,
    output logic [47:0] rsp_data,
    output logic [7:0]  lnb_ctrl,
    output logic [7:0]  gpio_out,
    output logic [7:0]  gpio_oe
);

    kind_e kind;
    logic  accept;
    logic  fire;

    vreq_decode #(.TABLE_SIZE(TABLE_SIZE)) u_decode (
        .code   (req_code),
        .dir_in (req_dir_in),
        .kind   (kind),
        .accept (accept)
    );

    assign fire = req_valid && accept;

    vreq_portctl u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .kind     (kind),
        .val      (req_value),
        .lnb_ctrl (lnb_ctrl),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe)
    );

    vreq_resp #(
        .VER_PATCH (VER_PATCH),
        .VER_MINOR (VER_MINOR),
        .VER_MAJOR (VER_MAJOR),
        .BUILD_DAY (BUILD_DAY),
        .BUILD_MON (BUILD_MON),
        .BUILD_YR  (BUILD_YR)
    ) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .accept     (accept),
        .kind       (kind),
        .val        (req_value),
        .status_bit (status_in[0]),
        .done       (rsp_done),
        .stall      (rsp_stall),
        .len        (rsp_len),
        .data       (rsp_data)
    );

    // R10: accepted host-to-device requests complete with a zero count
    p_out_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_stall && !$past(req_dir_in)) |-> (rsp_len == 3'd0));

    // R3: a rejected request leaves the port outputs unchanged
    p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> ($stable(lnb_ctrl) && $stable(gpio_out) && $stable(gpio_oe)));

endmodule

// File: tb/sim_vreq_dispatch.sv
`timescale 1ns/1ps
module sim_vreq_dispatch;

    localparam int         TS   = 30;
    localparam logic [7:0] V_PA = 8'h03, V_MI = 8'h07, V_MA = 8'h02;
    localparam logic [7:0] B_DA = 8'h15, B_MO = 8'h06, B_YR = 8'h0B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_code = 8'h00;
    logic [7:0]  req_value = 8'h00;
    logic        req_dir_in = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        rsp_done, rsp_stall;
    logic [2:0]  rsp_len;
    logic [47:0] rsp_data;
    logic [7:0]  lnb_ctrl, gpio_out, gpio_oe;

    always #2.5 clk = ~clk;

    vreq_dispatch #(
        .TABLE_SIZE(TS), .VER_PATCH(V_PA), .VER_MINOR(V_MI), .VER_MAJOR(V_MA),
        .BUILD_DAY(B_DA), .BUILD_MON(B_MO), .BUILD_YR(B_YR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_value(req_value), .req_dir_in(req_dir_in), .status_in(status_in),
        .rsp_done(rsp_done), .rsp_stall(rsp_stall), .rsp_len(rsp_len),
        .rsp_data(rsp_data), .lnb_ctrl(lnb_ctrl), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // reference model state
    int   m_cnt   = 0;
    bit   m_boost = 1'b0;
    int   m_out   = 8'h00;
    int   m_oe    = 8'hF0;

    // expected outputs after the next edge
    bit          e_done, e_stall;
    int          e_len;
    logic [47:0] e_data;

    function automatic bit model_accept(int c, bit dir);
        bit wants_in, wants_out;
        if (c < 128 || (c - 128) >= TS) return 1'b0;
        wants_in  = (c == 'h91) || (c == 'h92) || (c == 'h98);
        wants_out = (c == 'h94) || (c == 'h96) || (c == 'h97);
        return dir ? wants_in : wants_out;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] e_lnb;
        e_lnb = m_boost ? 8'h6A : 8'h62;
        vectors++;
        if (rsp_done !== e_done || rsp_stall !== e_stall || rsp_len !== 3'(e_len) ||
            rsp_data !== e_data || lnb_ctrl !== e_lnb || gpio_out !== 8'(m_out) ||
            gpio_oe !== 8'(m_oe)) begin
            miscompares++;
            $display("FAIL %s: got done=%b stall=%b len=%0d data=%h lnb=%h out=%h oe=%h exp done=%b stall=%b len=%0d data=%h lnb=%h out=%h oe=%h",
                     tag, rsp_done, rsp_stall, rsp_len, rsp_data, lnb_ctrl, gpio_out, gpio_oe,
                     e_done, e_stall, e_len, e_data, e_lnb, 8'(m_out), 8'(m_oe));
        end
    endtask

    // drive one cycle of inputs, advance the model, check after the edge
    task automatic step(input bit v, input int c, input int val, input bit dir,
                        input int st, input string tag);
        bit acc;
        req_valid  = v;
        req_code   = 8'(c);
        req_value  = 8'(val);
        req_dir_in = dir;
        status_in  = 8'(st);
        acc     = v && model_accept(c, dir);
        e_done  = v;
        e_stall = v && !acc;
        e_len   = 0;
        e_data  = '0;
        if (acc) begin
            case (c)
                'h91: begin
                    m_cnt = (val != 0) ? (m_cnt + 1) % 256 : (m_cnt + 255) % 256;
                    e_len = 1;
                    e_data[7:0] = 8'(m_cnt);
                end
                'h92: begin
                    e_len  = 6;
                    e_data = {B_YR, B_MO, B_DA, V_MA, V_MI, V_PA};
                end
                'h94: m_boost = (val != 0);
                'h96: begin
                    if (val != 0) begin
                        m_out = (m_out & ~8) | 6;
                        m_oe  = 'hFE;
                    end else begin
                        m_oe  = 'hF0;
                    end
                end
                'h97: m_out = (m_out & 'hF1) | (val & 'h0E);
                'h98: begin
                    e_len = 1;
                    e_data[7:0] = 8'(st & 1);
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got no end, exp end of scenario list");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        e_done = 0; e_stall = 0; e_len = 0; e_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R6 R7 reset state");
        rst_n = 1'b1;

        step(0, 0, 0, 0, 0, "R1 idle");
        step(0, 'h94, 1, 0, 0, "R1 ignored without strobe");
        // counter up, down past zero, wrap up
        step(1, 'h91, 1, 1, 0, "R4 inc");
        step(1, 'h91, 7, 1, 0, "R4 inc");
        step(1, 'h91, 0, 1, 0, "R4 dec");
        step(1, 'h91, 0, 1, 0, "R4 dec");
        step(1, 'h91, 0, 1, 0, "R4 wrap below zero");
        step(1, 'h91, 5, 1, 0, "R4 wrap above 255");
        step(0, 0, 0, 0, 0, "R1 gap");
        step(1, 'h92, 0, 1, 0, "R5 version bytes");
        step(1, 'h94, 'h20, 0, 0, "R6 boost on, R10 zero count");
        step(1, 'h94, 0, 0, 0, "R6 boost off");
        step(1, 'h94, 1, 0, 0, "R6 boost on again");
        step(1, 'h96, 1, 0, 0, "R7 active mode");
        step(1, 'h97, 'h08, 0, 0, "R8 pin write");
        step(1, 'h97, 'hFF, 0, 0, "R8 pin write all");
        step(1, 'h96, 0, 0, 0, "R7 default mode keeps pins");
        step(1, 'h97, 'hF5, 0, 0, "R8 pin write masked");
        step(1, 'h96, 'h80, 0, 0, "R7 active mode again");
        step(1, 'h98, 0, 1, 'hFE, "R9 status low");
        step(1, 'h98, 0, 1, 'h01, "R9 status high");
        step(1, 'h98, 0, 1, 'hA3, "R9 status masked");
        // rejections
        step(1, 'h93, 0, 1, 0, "R3 eeprom serial");
        step(1, 'h95, 0, 1, 0, "R3 eeprom id");
        step(1, 'h8F, 'h55, 0, 0, "R3 unserved code");
        step(1, 'h91, 1, 0, 0, "R3 counter wrong direction");
        step(1, 'h91, 1, 1, 0, "R4 count untouched by rejection");
        step(1, 'h94, 0, 1, 0, "R3 boost wrong direction");
        step(1, 'h97, 0, 1, 0, "R3 pins wrong direction");
        step(1, 'h98, 0, 0, 1, "R3 status wrong direction");
        step(1, 'h7F, 1, 0, 0, "R2 below table");
        step(1, 'h9D, 1, 1, 0, "R2 last entry unserved");
        step(1, 'h9E, 1, 0, 0, "R2 past table");
        step(1, 'hFF, 1, 1, 0, "R2 top code");
        step(1, 'h00, 0, 0, 0, "R2 zero code");
        step(1, 'h92, 0, 1, 0, "R5 version after rejections");
        step(0, 0, 0, 0, 0, "R1 final idle");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule